// File: doc/BRIEF.md
# Masked Register Update Host

This block is the host side of a word-addressed memory-mapped control port with a stall signal (`avm_waitrequest_i`) and a separate read-data strobe (`avm_readdatavalid_i`). A requester gives it one command at a time: a byte address, an operation code, write data, a bit mask and byte enables. The block turns the byte address into a word address and runs the bus handshake. It raises `busy_o` while it works and gives a single `done_o` pulse when the command is finished.

A masked update replaces only selected bits of a word that also holds other settings. The block reads the word and waits for the returned data. It then replaces only the masked bits with the new data and writes the whole word back, so every bit outside the mask keeps its value. Plain reads and plain byte-enabled writes are also supported. Only one bus request is active at any time. Read and write are never raised together.

Top module: `mm_rmw_host`

## Requirements
- R1: While `rst_ni` is low, including a reset in the middle of a transaction, `busy_o`, `done_o`, `avm_read_o` and `avm_write_o` are low. After reset the host is idle and accepts a new command.
- R2: For every operation, `avm_address_o` equals the command byte address shifted right by two.
- R3: A raised read request keeps `avm_read_o` high and the address unchanged while `avm_waitrequest_i` is high. The request counts as accepted only at a clock edge where it is high and `avm_waitrequest_i` is low. It is low in the cycle after acceptance. The target may raise `avm_waitrequest_i` in the same cycle the request first appears.
- R4: Read data is taken only at the clock edge where `avm_readdatavalid_i` is high. Data present on `avm_readdata_i` in other cycles is never used. `rdata_o` holds the taken word when `done_o` is high, and `done_o` stays high for exactly one cycle.
- R5: A write (op `2'b01`) drives `avm_writedata_o` with the command data and `avm_byteenable_o` with the command byte enables. It holds address and data while stalled, and gives one `done_o` pulse after acceptance.
- R6: A masked update (op `2'b10`) does one read and then one write to the same word. The written value is `(old & ~mask) | (new & mask)`, the byte enables are `4'hF`, and `rdata_o` at `done_o` is the old word.
- R7: `avm_read_o` and `avm_write_o` are never high in the same cycle. A new read is never issued while read data is still pending.
- R8: `busy_o` rises in the cycle after a command is accepted and stays high until the final handshake completes. Commands presented while `busy_o` is high produce no bus traffic and have no effect.
- R9: Op code `2'b11` is ignored: no bus request, no `busy_o`, no `done_o`. A read is op `2'b00`.
- R10: Reads and the read phase of a masked update drive `avm_byteenable_o` as `4'hF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; taken when idle |
| cmd_op_i | input | 2 | 00 read, 01 write, 10 masked update, 11 ignored |
| cmd_addr_i | input | 16 | Byte address |
| cmd_wdata_i | input | 32 | Write / new field data |
| cmd_mask_i | input | 32 | Bit mask for masked update |
| cmd_be_i | input | 4 | Byte enables for plain write |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data (old word for masked update) |
| avm_address_o | output | 14 | Word address |
| avm_read_o | output | 1 | Read request |
| avm_write_o | output | 1 | Write request |
| avm_byteenable_o | output | 4 | Byte enables |
| avm_writedata_o | output | 32 | Write data |
| avm_readdata_i | input | 32 | Read data from target |
| avm_readdatavalid_i | input | 1 | Read data strobe |
| avm_waitrequest_i | input | 1 | Target stall |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 14-bit word address, four byte lanes and a 16-bit byte address. With these values it can issue byte addresses that have non-zero low bits and the topmost address, which maps to word `0x3FFF`. It can also drive byte-enable patterns that leave single lanes untouched. The target model adds a stall of 0 to 15 cycles and a read latency of 1 to 15 cycles, and it drives junk data whenever the strobe is low. Because of this, a host that accepts too early or captures data in the wrong cycle returns wrong data.

// File: rtl/mm_rmw_pkg.sv
package mm_rmw_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } st_e;
endpackage

// File: rtl/mm_rmw_addr.sv
module mm_rmw_addr #(
  parameter int WORD_AW = 14,
  parameter int OFFS_W  = 2,
  localparam int BYTE_AW = WORD_AW + OFFS_W
) (
  input  logic [BYTE_AW-1:0] byte_addr_i,
  output logic [WORD_AW-1:0] word_addr_o
);
  generate
    if (OFFS_W > 0) begin : g_shift
      logic unused_offs;
      assign unused_offs = ^byte_addr_i[OFFS_W-1:0];
      assign word_addr_o = byte_addr_i[BYTE_AW-1:OFFS_W];
    end else begin : g_pass
      assign word_addr_o = byte_addr_i;
    end
  endgenerate
endmodule

// File: rtl/mm_rmw_merge.sv
module mm_rmw_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged_o[i] = mask_i[i] ? new_i[i] : old_i[i];
  end
endmodule

// File: rtl/mm_rmw_seq.sv
module mm_rmw_seq
  import mm_rmw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 14,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  op_e                cmd_op_i,
  input  logic [WORD_AW-1:0] cmd_waddr_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [DATA_W-1:0]  cmd_mask_i,
  input  logic [BE_W-1:0]    cmd_be_i,
  input  logic [DATA_W-1:0]  merged_i,
  output logic [DATA_W-1:0]  wdata_q_o,
  output logic [DATA_W-1:0]  mask_q_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [WORD_AW-1:0] bus_addr_o,
  output logic               bus_rd_o,
  output logic               bus_wr_o,
  output logic [BE_W-1:0]    bus_be_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  input  logic               bus_rvalid_i,
  input  logic               bus_wait_i
);
  st_e                state_q;
  op_e                op_q;
  logic [WORD_AW-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q, mask_q, bus_wdata_q, rdata_q;
  logic [BE_W-1:0]    be_q;
  logic               rd_q, wr_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      wdata_q     <= '0;
      mask_q      <= '0;
      bus_wdata_q <= '0;
      rdata_q     <= '0;
      be_q        <= '0;
      rd_q        <= 1'b0;
      wr_q        <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i && cmd_op_i != OP_NONE) begin
            addr_q  <= cmd_waddr_i;
            wdata_q <= cmd_wdata_i;
            mask_q  <= cmd_mask_i;
            op_q    <= cmd_op_i;
            if (cmd_op_i == OP_WRITE) begin
              bus_wdata_q <= cmd_wdata_i;
              be_q        <= cmd_be_i;
              wr_q        <= 1'b1;
              state_q     <= ST_WR_REQ;
            end else begin
              be_q    <= '1;
              rd_q    <= 1'b1;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          // acceptance only with request already on the bus
          if (!bus_wait_i) begin
            rd_q    <= 1'b0;
            state_q <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (bus_rvalid_i) begin
            rdata_q <= bus_rdata_i;
            if (op_q == OP_RMW) begin
              bus_wdata_q <= merged_i;
              be_q        <= '1;
              wr_q        <= 1'b1;
              state_q     <= ST_WR_REQ;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WR_REQ: begin
          if (!bus_wait_i) begin
            wr_q    <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_rd_o    = rd_q;
  assign bus_wr_o    = wr_q;
  assign bus_be_o    = be_q;
  assign bus_wdata_o = bus_wdata_q;
  assign wdata_q_o   = wdata_q;
  assign mask_q_o    = mask_q;

  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_q && wr_q)); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q && bus_wait_i |=> rd_q && $stable(addr_q)); // R3
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q && bus_wait_i |=> wr_q && $stable(addr_q) && $stable(bus_wdata_q)); // R5
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q || wr_q) && !bus_wait_i |=> !rd_q && !wr_q); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_valid_i |=> $stable(addr_q) && $stable(op_q)); // R8
  AST_RD_BE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> be_q == {BE_W{1'b1}}); // R10
endmodule

// File: rtl/mm_rmw_host.sv
module mm_rmw_host
  import mm_rmw_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WORD_AW  = 14,
  localparam int BE_W    = DATA_W / 8,
  localparam int OFFS_W  = $clog2(BE_W),
  localparam int BYTE_AW = WORD_AW + OFFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [BYTE_AW-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [DATA_W-1:0]  cmd_mask_i,
  input  logic [BE_W-1:0]    cmd_be_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [WORD_AW-1:0] avm_address_o,
  output logic               avm_read_o,
  output logic               avm_write_o,
  output logic [BE_W-1:0]    avm_byteenable_o,
  output logic [DATA_W-1:0]  avm_writedata_o,
  input  logic [DATA_W-1:0]  avm_readdata_i,
  input  logic               avm_readdatavalid_i,
  input  logic               avm_waitrequest_i
);
  logic [WORD_AW-1:0] waddr;
  logic [DATA_W-1:0]  merged, wdata_q, mask_q;

  mm_rmw_addr #(.WORD_AW(WORD_AW), .OFFS_W(OFFS_W)) u_addr (
    .byte_addr_i (cmd_addr_i),
    .word_addr_o (waddr)
  );

  mm_rmw_merge #(.DATA_W(DATA_W)) u_merge (
    .old_i    (avm_readdata_i),
    .new_i    (wdata_q),
    .mask_i   (mask_q),
    .merged_o (merged)
  );

  mm_rmw_seq #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (op_e'(cmd_op_i)),
    .cmd_waddr_i  (waddr),
    .cmd_wdata_i  (cmd_wdata_i),
    .cmd_mask_i   (cmd_mask_i),
    .cmd_be_i     (cmd_be_i),
    .merged_i     (merged),
    .wdata_q_o    (wdata_q),
    .mask_q_o     (mask_q),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .bus_addr_o   (avm_address_o),
    .bus_rd_o     (avm_read_o),
    .bus_wr_o     (avm_write_o),
    .bus_be_o     (avm_byteenable_o),
    .bus_wdata_o  (avm_writedata_o),
    .bus_rdata_i  (avm_readdata_i),
    .bus_rvalid_i (avm_readdatavalid_i),
    .bus_wait_i   (avm_waitrequest_i)
  );

  AST_WORD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o && cmd_op_i != 2'b11
    |=> avm_address_o == $past(cmd_addr_i[BYTE_AW-1:OFFS_W])); // R2
  AST_MERGE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avm_write_o) && $past(avm_readdatavalid_i) && busy_o
    |-> ((((avm_writedata_o ^ $past(avm_readdata_i)) & ~mask_q) == '0)
         && (((avm_writedata_o ^ wdata_q) & mask_q) == '0))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !avm_read_o && !avm_write_o); // R8
  AST_OP_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i && cmd_op_i == 2'b11 |=> !busy_o); // R9
endmodule

// File: tb/sim_mm_rmw_host.sv
module sim_mm_rmw_host;
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] mask;
    logic [3:0]  be;
    logic [3:0]  wt;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 16'h0008, 32'h0000_0000, 32'h0000_0000, 4'hF, 4'd0, 4'd1},
    '{2'b01, 16'h0014, 32'h1234_5678, 32'h0000_0000, 4'hF, 4'd0, 4'd1},
    '{2'b00, 16'h0014, 32'h0000_0000, 32'h0000_0000, 4'hF, 4'd3, 4'd4},
    '{2'b01, 16'h0020, 32'hCAFE_F00D, 32'h0000_0000, 4'h5, 4'd2, 4'd1},
    '{2'b10, 16'h0004, 32'hFFFF_FFFF, 32'h0000_FF00, 4'hF, 4'd1, 4'd2},
    '{2'b10, 16'h0021, 32'h0000_0000, 32'hF0F0_F0F0, 4'hF, 4'd0, 4'd1},
    '{2'b00, 16'hFFFC, 32'h0000_0000, 32'h0000_0000, 4'hF, 4'd5, 4'd7},
    '{2'b10, 16'h003C, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 4'hF, 4'd4, 4'd3},
    '{2'b10, 16'h0010, 32'hAAAA_AAAA, 32'h0000_0000, 4'hF, 4'd2, 4'd2},
    '{2'b01, 16'h0003, 32'h0000_0000, 32'h0000_0000, 4'h8, 4'd1, 4'd1},
    '{2'b00, 16'h0002, 32'h0000_0000, 32'h0000_0000, 4'hF, 4'd0, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0, cmd_mask = '0;
  logic [3:0]  cmd_be = '0;
  logic        busy, done;
  logic [31:0] rdata;
  logic [13:0] addr;
  logic        rd, wr;
  logic [3:0]  be;
  logic [31:0] wdata, rdata_in;
  logic        rvalid, wreq;

  always #10 clk = ~clk;

  mm_rmw_host u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_mask_i(cmd_mask),
    .cmd_be_i(cmd_be), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .avm_address_o(addr), .avm_read_o(rd), .avm_write_o(wr),
    .avm_byteenable_o(be), .avm_writedata_o(wdata), .avm_readdata_i(rdata_in),
    .avm_readdatavalid_i(rvalid), .avm_waitrequest_i(wreq)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'hA5A5_0000 | (i * 32'h0000_1111);
  endfunction

  // target model
  logic [3:0]  wait_n = '0, lat_n = 4'd1, cnt, pc, ridx;
  logic [31:0] mem [16];
  logic [13:0] last_rd_addr, last_wr_addr, prev_addr;
  logic [3:0]  last_rd_be, last_wr_be;
  logic [31:0] last_wr_data, prev_wd;
  int          rd_cnt, wr_cnt, proto_err, e;
  logic        prev_rd_wait, prev_wr_wait, acc_q;
  wire         req = rd | wr;
  wire         acc = req && !wreq;

  assign wreq     = req && (cnt != wait_n);
  assign rvalid   = (pc == 4'd1);
  assign rdata_in = rvalid ? mem[ridx] : 32'hDEAD_BEEF;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pc <= '0; ridx <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      rd_cnt <= 0; wr_cnt <= 0;
      prev_rd_wait <= 1'b0; prev_wr_wait <= 1'b0; acc_q <= 1'b0;
      prev_addr <= '0; prev_wd <= '0;
      last_rd_addr <= '0; last_wr_addr <= '0; last_rd_be <= '0;
      last_wr_be <= '0; last_wr_data <= '0;
    end else begin
      e = 0;
      if (req) cnt <= acc ? 4'd0 : cnt + 4'd1;
      if (pc != 0) pc <= pc - 4'd1;
      if (acc && rd) begin
        if (pc > 4'd1) e++;
        pc <= lat_n; ridx <= addr[3:0]; rd_cnt <= rd_cnt + 1;
        last_rd_addr <= addr; last_rd_be <= be;
      end
      if (acc && wr) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) mem[addr[3:0]][8*b +: 8] <= wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
        last_wr_addr <= addr; last_wr_be <= be; last_wr_data <= wdata;
      end
      if (rd && wr) e++;
      if (prev_rd_wait && (!rd || addr != prev_addr)) e++;
      if (prev_wr_wait && (!wr || addr != prev_addr || wdata != prev_wd)) e++;
      if (acc_q && req) e++;
      prev_rd_wait <= rd && wreq;
      prev_wr_wait <= wr && wreq;
      prev_addr <= addr; prev_wd <= wdata; acc_q <= acc;
      proto_err <= proto_err + e;
    end
  end

  initial proto_err = 0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_mem [16];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reinit_exp();
    for (int i = 0; i < 16; i++) exp_mem[i] = init_word(i);
  endtask

  task automatic run_cmd(input vec_t v, output logic ok);
    int t;
    wait_n = v.wt; lat_n = v.lat;
    cmd_op = v.op; cmd_addr = v.addr; cmd_wdata = v.wdata;
    cmd_mask = v.mask; cmd_be = v.be; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    ok = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    logic [31:0] old, nw;
    int k, r0, w0, bl;
    reinit_exp();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset busy/done/rd/wr", {28'h0, busy, done, rd, wr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      k = int'(VECS[i].addr >> 2) & 15;
      run_cmd(VECS[i], ok);
      check("R4 done seen", {31'h0, ok}, 32'h1);
      if (VECS[i].op == 2'b00) begin
        check("R4 read data", rdata, exp_mem[k]);
        check("R2 read word address", {18'h0, last_rd_addr}, {18'h0, VECS[i].addr[15:2]});
        check("R10 read byte enables", {28'h0, last_rd_be}, 32'hF);
      end else if (VECS[i].op == 2'b01) begin
        for (int b = 0; b < 4; b++)
          if (VECS[i].be[b]) exp_mem[k][8*b +: 8] = VECS[i].wdata[8*b +: 8];
        check("R5 write data", last_wr_data, VECS[i].wdata);
        check("R5 write byte enables", {28'h0, last_wr_be}, {28'h0, VECS[i].be});
        check("R2 write word address", {18'h0, last_wr_addr}, {18'h0, VECS[i].addr[15:2]});
        check("R5 memory after write", mem[k], exp_mem[k]);
      end else begin
        old = exp_mem[k];
        nw  = (old & ~VECS[i].mask) | (VECS[i].wdata & VECS[i].mask);
        exp_mem[k] = nw;
        check("R6 old word returned", rdata, old);
        check("R6 merged write value", last_wr_data, nw);
        check("R6 write-back byte enables", {28'h0, last_wr_be}, 32'hF);
        check("R2 rmw word address", {18'h0, last_wr_addr}, {18'h0, VECS[i].addr[15:2]});
      end
      @(negedge clk);
      check("R4 done one cycle", {31'h0, done}, 32'h0);
      check("R8 idle after done", {31'h0, busy}, 32'h0);
    end

    // R9 op 11 ignored
    r0 = rd_cnt; w0 = wr_cnt; bl = 0;
    cmd_op = 2'b11; cmd_addr = 16'h0008; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (busy || done || rd || wr) bl++;
      @(negedge clk);
    end
    check("R9 op 11 no activity", bl, 0);
    check("R9 op 11 no bus traffic", rd_cnt + wr_cnt, r0 + w0);

    // R8 commands while busy ignored
    r0 = rd_cnt; w0 = wr_cnt; bl = 0;
    wait_n = 4'd6; lat_n = 4'd6;
    cmd_op = 2'b10; cmd_addr = 16'h0018; cmd_wdata = 32'h0000_0001;
    cmd_mask = 32'h0000_000F; cmd_valid = 1'b1;
    @(negedge clk);
    check("R8 busy after accept", {31'h0, busy}, 32'h1);
    cmd_op = 2'b01; cmd_addr = 16'h001C; cmd_wdata = 32'h0; cmd_be = 4'hF;
    for (int c = 0; c < 4; c++) @(negedge clk);
    cmd_valid = 1'b0;
    k = 0;
    while (!done && k < 200) begin
      if (!busy) bl++;
      @(negedge clk); k++;
    end
    exp_mem[6] = (exp_mem[6] & ~32'hF) | 32'h1;
    check("R8 busy held until final handshake", bl, 0);
    repeat (5) @(negedge clk);
    check("R8 single write during busy", wr_cnt - w0, 1);
    check("R8 single read during busy", rd_cnt - r0, 1);
    check("R8 ignored write left memory", mem[7], exp_mem[7]);
    check("R6 rmw under busy stimulus", mem[6], exp_mem[6]);

    // R7 / R3 protocol checks
    check("R7 R3 protocol violations", proto_err, 0);

    // R1 reset mid-transaction
    wait_n = 4'd15; lat_n = 4'd1;
    cmd_op = 2'b00; cmd_addr = 16'h0008; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 read held while stalled", {31'h0, rd}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-transaction reset", {28'h0, busy, done, rd, wr}, 32'h0);
    rst_n = 1'b1;
    reinit_exp();
    @(negedge clk);
    run_cmd('{2'b00, 16'h0028, 32'h0, 32'h0, 4'hF, 4'd2, 4'd3}, ok);
    check("R1 read after reset", rdata, exp_mem[10]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule